// File: doc/BRIEF.md
# Weighted Subset Fitness Evaluator

This block scores one candidate gene subset for a search algorithm. It computes F = w1·A + w2·(M − R)/M. A is the classification accuracy of the subset. R is the number of genes the subset keeps. M is the total number of genes. w1 and w2 are the weights. A higher F marks a better subset. The requesting controller presents the operands together with a one-cycle `start` pulse. The block then sends back the score with a one-cycle `done_o` pulse.

Inside the block, a small phase sequencer starts three independent sub-terms in the same phase, each on its own operator:

- the product w1·A on the multiplier,
- the quotient w2/M on a multi-cycle restoring divider,
- the difference M − R, widened to fixed point by a converter.

The sequencer waits for the divider to report completion. It then reuses the single multiplier for (w2/M)·(M − R) and closes with one saturating addition. All arithmetic is unsigned fixed point, so no floating-point operator is needed.

Top module: `fit_eval`

## Requirements
- R1: After reset, `done_o` is 0, `fit_o` is 0 and `err_o` is 0.
- R2: Fractional values (w1, A, w2, F) are unsigned Q8.16 in 24 bits. A raw value of 0x010000 means 1.0. M and R are unsigned 16-bit integers with R ≤ M. For M > 0 the result is F = sat(T1 + T2), where:
  - T1 = sat(floor(w1·A / 2^16)),
  - T2 = sat(floor(w2 / M)·(M − R)),
  - sat() clamps to 0xFFFFFF.
- R3: The quotient w2/M is truncated toward zero on the raw Q8.16 value. For example, w2 = 0x010000 with M = 3 gives 21845.
- R4: When a product or the final sum exceeds 0xFFFFFF, the value clamps to 0xFFFFFF instead of wrapping.
- R5: For M > 0, `done_o` is high in the cycle that follows the 27th clock edge after the edge that samples `start`. In general this is NW_DIV + 3 edges, where NW_DIV is the 24-bit width of w2.
- R6: `done_o` is high for exactly one cycle per accepted request.
- R7: `fit_o` and `err_o` change only in a cycle where `done_o` is high. They then hold their values until the next `done_o`.
- R8: A `start` that arrives while a request is in progress is ignored. This includes the cycle in which `done_o` is high. An ignored start produces no extra `done_o`, and its operands do not affect the result being computed.
- R9: If M = 0, the block returns `fit_o` = 0 with `err_o` = 1. `done_o` is then high in the cycle right after the edge that samples `start`.
- R10: A later request with M > 0 clears `err_o` to 0 when its `done_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; operands are sampled with it |
| w1_i | input | 24 | Weight on accuracy, Q8.16 |
| acc_i | input | 24 | Accuracy A, Q8.16 |
| w2_i | input | 24 | Weight on subset size, Q8.16 |
| total_i | input | 16 | Total gene count M |
| sel_i | input | 16 | Selected gene count R |
| done_o | output | 1 | One-cycle result strobe |
| fit_o | output | 24 | Fitness F, Q8.16, held between strobes |
| err_o | output | 1 | Set when M was zero; held between strobes |

## Verification
The two functions that can fall in the same cycle are the result hand-back and the arrival of a new request. The bench provokes this by pulsing `start`, with different operands, in exactly the cycle where `done_o` is high. A second variant pulses `start` in the middle of the divide phase. Each case is judged at the ports in three ways:

- the scoreboard must see exactly one strobe carrying the value predicted from the first operands, at the predicted cycle;
- any strobe that arrives with no queued expectation is reported as a failure;
- `fit_o` must not move during the idle window that follows, which is longer than a full computation.

// File: rtl/fit_pkg.sv
package fit_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PAR,
        PH_MUL2,
        PH_ADD,
        PH_DONE
    } phase_t;

endpackage

// File: rtl/fit_int2fix.sv
module fit_int2fix #(
    parameter int IW   = 16,
    parameter int FRAC = 16,
    localparam int OW  = IW + FRAC
) (
    input  logic [IW-1:0] int_i,
    output logic [OW-1:0] fix_o
);
    assign fix_o = {int_i, {FRAC{1'b0}}};
endmodule

// File: rtl/fit_mul_sat.sv
module fit_mul_sat #(
    parameter int AW   = 24,
    parameter int BW   = 32,
    parameter int FRAC = 16,
    parameter int OW   = 24,
    localparam int PW  = AW + BW
) (
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    output logic [OW-1:0] p_o
);
    logic [PW-1:0] full;
    logic [PW-1:0] full_sh;

    assign full    = {{BW{1'b0}}, a_i} * {{AW{1'b0}}, b_i};
    assign full_sh = full >> FRAC;

    generate
        if (PW > OW) begin : g_clamp
            always_comb begin
                if (|full_sh[PW-1:OW]) p_o = {OW{1'b1}};
                else                   p_o = full_sh[OW-1:0];
            end
        end else begin : g_pass
            assign p_o = full_sh[OW-1:0];
        end
    endgenerate
endmodule

// File: rtl/fit_div_restore.sv
module fit_div_restore #(
    parameter int NUMW = 24,
    parameter int DENW = 16,
    localparam int CNTW = $clog2(NUMW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [NUMW-1:0] num_i,
    input  logic [DENW-1:0] den_i,
    output logic [NUMW-1:0] quo_o,
    output logic            vld_o
);
    typedef struct packed {
        logic [DENW:0]   rem;
        logic [NUMW-1:0] quo;
        logic [NUMW-1:0] num;
        logic [DENW-1:0] den;
        logic [CNTW-1:0] cnt;
        logic            vld;
    } div_st_t;

    div_st_t st_q, st_d;
    logic [DENW:0] shifted;
    logic          fits;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        shifted  = {st_q.rem[DENW-1:0], st_q.quo[NUMW-1]};
        fits     = shifted >= {1'b0, st_q.den};
        if (go_i) begin
            st_d.rem = '0;
            st_d.quo = num_i;
            st_d.num = num_i;
            st_d.den = den_i;
            st_d.cnt = CNTW'(NUMW);
        end else if (st_q.cnt != '0) begin
            st_d.rem = fits ? (shifted - {1'b0, st_q.den}) : shifted;
            st_d.quo = {st_q.quo[NUMW-2:0], fits};
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.vld = (st_q.cnt == CNTW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quo_o = st_q.quo;
    assign vld_o = st_q.vld;

    // R3: quotient and remainder reconstruct the captured dividend
    a_r3_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (({{DENW{1'b0}}, st_q.quo} * {{NUMW{1'b0}}, st_q.den}
                       + {{(NUMW-1){1'b0}}, st_q.rem}) == {{DENW{1'b0}}, st_q.num})
                     && (st_q.rem < {1'b0, st_q.den}));

    // R5: completion is a single-cycle strobe
    a_r5_div_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);
endmodule

// File: rtl/fit_eval.sv
module fit_eval
    import fit_pkg::*;
#(
    parameter int IB   = 8,
    parameter int FRAC = 16,
    parameter int NW   = 16,
    localparam int QW  = IB + FRAC,
    localparam int CW  = NW + FRAC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [QW-1:0] w1_i,
    input  logic [QW-1:0] acc_i,
    input  logic [QW-1:0] w2_i,
    input  logic [NW-1:0] total_i,
    input  logic [NW-1:0] sel_i,
    output logic          done_o,
    output logic [QW-1:0] fit_o,
    output logic          err_o
);
    typedef struct packed {
        phase_t          ph;
        logic [QW-1:0]   w1;
        logic [QW-1:0]   acc;
        logic [NW-1:0]   tot;
        logic [NW-1:0]   sel;
        logic [QW-1:0]   prod1;
        logic [CW-1:0]   conv;
        logic [QW-1:0]   quo;
        logic [QW-1:0]   prod2;
        logic [QW-1:0]   fit;
        logic            err;
        logic            done;
    } ev_st_t;

    ev_st_t st_q, st_d;

    logic          div_go;
    logic [QW-1:0] div_quo;
    logic          div_vld;
    logic [CW-1:0] cnv_out;
    logic [QW-1:0] mul_a;
    logic [CW-1:0] mul_b;
    logic [QW-1:0] mul_p;
    logic [QW:0]   sum_w;

    assign div_go = (st_q.ph == PH_IDLE) && start && (total_i != '0);

    fit_div_restore #(.NUMW(QW), .DENW(NW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (div_go),
        .num_i (w2_i),
        .den_i (total_i),
        .quo_o (div_quo),
        .vld_o (div_vld)
    );

    fit_int2fix #(.IW(NW), .FRAC(FRAC)) u_cnv (
        .int_i (st_q.tot - st_q.sel),
        .fix_o (cnv_out)
    );

    // single multiplier shared between the parallel phase and the second product
    assign mul_a = (st_q.ph == PH_PAR) ? st_q.w1 : st_q.quo;
    assign mul_b = (st_q.ph == PH_PAR) ? CW'(st_q.acc) : st_q.conv;

    fit_mul_sat #(.AW(QW), .BW(CW), .FRAC(FRAC), .OW(QW)) u_mul (
        .a_i (mul_a),
        .b_i (mul_b),
        .p_o (mul_p)
    );

    assign sum_w = {1'b0, st_q.prod1} + {1'b0, st_q.prod2};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.w1  = w1_i;
                    st_d.acc = acc_i;
                    st_d.tot = total_i;
                    st_d.sel = sel_i;
                    if (total_i == '0) begin
                        st_d.fit  = '0;
                        st_d.err  = 1'b1;
                        st_d.done = 1'b1;
                        st_d.ph   = PH_DONE;
                    end else begin
                        st_d.ph = PH_PAR;
                    end
                end
            end
            PH_PAR: begin
                st_d.prod1 = mul_p;
                st_d.conv  = cnv_out;
                if (div_vld) begin
                    st_d.quo = div_quo;
                    st_d.ph  = PH_MUL2;
                end
            end
            PH_MUL2: begin
                st_d.prod2 = mul_p;
                st_d.ph    = PH_ADD;
            end
            PH_ADD: begin
                st_d.fit  = sum_w[QW] ? {QW{1'b1}} : sum_w[QW-1:0];
                st_d.err  = 1'b0;
                st_d.done = 1'b1;
                st_d.ph   = PH_DONE;
            end
            PH_DONE: begin
                st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign fit_o  = st_q.fit;
    assign err_o  = st_q.err;

    logic          busy_w;
    logic [NW-1:0] tot_l;
    logic [QW-1:0] w1_l;
    assign busy_w = (st_q.ph != PH_IDLE);
    assign tot_l  = st_q.tot;
    assign w1_l   = st_q.w1;

    // R6: strobe lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: outputs move only together with the strobe
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fit_o) || !$stable(err_o)) |-> done_o);

    // R9: error result carries a zero score
    a_r9_zero_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (fit_o == '0));

    // R8: a request during a busy phase leaves the captured operands alone
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && start) |=> ($stable(tot_l) && $stable(w1_l)));

    // R5: divider completion is only seen while waiting for it
    a_r5_div_in_par: assert property (@(posedge clk) disable iff (!rst_n)
        div_vld |-> (st_q.ph == PH_PAR));
endmodule

// File: tb/fit_eval_test.sv
module fit_eval_test;
    localparam int QW  = 24;
    localparam int NW  = 16;
    localparam int LAT = 27;
    localparam longint MAXV = 64'hFFFFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [QW-1:0] w1_i = '0, acc_i = '0, w2_i = '0;
    logic [NW-1:0] total_i = '0, sel_i = '0;
    logic          done_o;
    logic [QW-1:0] fit_o;
    logic          err_o;

    always #2.5 clk = ~clk;

    fit_eval uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .w1_i(w1_i), .acc_i(acc_i), .w2_i(w2_i),
        .total_i(total_i), .sel_i(sel_i),
        .done_o(done_o), .fit_o(fit_o), .err_o(err_o)
    );

    typedef struct {
        longint fit;
        bit     err;
        int     due;
        string  req;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   finished = 1'b0;
    bit   prev_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint model(longint w1, longint a, longint w2, longint m, longint r);
        longint t1, t2, s;
        t1 = (w1 * a) >> 16;
        if (t1 > MAXV) t1 = MAXV;
        t2 = (w2 / m) * (m - r);
        if (t2 > MAXV) t2 = MAXV;
        s = t1 + t2;
        if (s > MAXV) s = MAXV;
        return s;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && prev_done)
                check(1'b0, "R6", "strobe wider than one cycle", 1, 0);
            if (done_o) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R8", "strobe with no pending request", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(longint'(fit_o) == e.fit, e.req, "score", longint'(fit_o), e.fit);
                    check(err_o == e.err, e.req, "error flag", longint'(err_o), longint'(e.err));
                    check(cyc == e.due, "R5", "strobe cycle", cyc, e.due);
                end
            end
        end
        prev_done <= done_o;
    end

    // driver: poke_at > 0 pulses a foreign start that many cycles after the request
    task automatic run(longint w1, longint a, longint w2, longint m, longint r,
                       int poke_at, string req);
        exp_t e;
        longint held_fit;
        bit     held_err;
        @(negedge clk);
        w1_i = QW'(w1); acc_i = QW'(a); w2_i = QW'(w2);
        total_i = NW'(m); sel_i = NW'(r);
        start = 1'b1;
        e.fit = (m == 0) ? 0 : model(w1, a, w2, m, r);
        e.err = (m == 0);
        e.due = cyc + 1 + ((m == 0) ? 0 : LAT);
        e.req = req;
        sbq.push_back(e);
        for (int k = 1; k <= poke_at + 1; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (k == poke_at) begin
                w1_i = 24'h123456; acc_i = 24'h0ABCDE; w2_i = 24'h777777;
                total_i = 16'd7; sel_i = 16'd2;
                start = 1'b1;
            end
        end
        @(negedge clk);
        start = 1'b0;
        wait (sbq.size() == 0);
        @(negedge clk);
        held_fit = longint'(fit_o);
        held_err = err_o;
        repeat (34) @(negedge clk);
        check(longint'(fit_o) == held_fit, "R7", "score held", longint'(fit_o), held_fit);
        check(err_o == held_err, "R7", "flag held", longint'(err_o), longint'(held_err));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0, "R1", "reset done", longint'(done_o), 0);
        check(fit_o == '0, "R1", "reset score", longint'(fit_o), 0);
        check(err_o == 1'b0, "R1", "reset flag", longint'(err_o), 0);

        run(64'hCCCC, 64'hE666, 64'h3333, 100, 10, 0, "R2");
        run(64'h10000, 64'h10000, 64'h10000, 3, 1, 0, "R3");
        run(64'h8000, 64'h4000, 64'hFFFFFF, 65535, 1, 0, "R2");
        run(64'h10000, 64'h8000, 64'h10000, 65535, 65535, 0, "R2");
        run(64'hFFFFFF, 64'hFFFFFF, 0, 5, 2, 0, "R4");
        run(64'h800000, 64'h10000, 64'hFFFFFF, 1, 0, 0, "R4");
        run(64'h20000, 64'h30000, 64'h10000, 4, 1, 5, "R8");
        run(64'h18000, 64'h8000, 64'h28000, 9, 4, LAT + 1, "R8");
        run(64'h10000, 64'h10000, 64'h10000, 0, 0, 0, "R9");
        run(64'h10000, 64'h4000, 64'h20000, 8, 3, 0, "R10");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule